// File: doc/BRIEF.md
# Leaf Page Entry Access Permission Checker

This block decides whether one memory access may proceed through a leaf page-table entry that a walker or translation cache has already found. Each request carries the six permission and status bits of the entry (read, write, execute, user, accessed, dirty), the kind of access, the current privilege level and two status modifiers. One modifier lets supervisor code touch user pages with loads and stores. The other lets loads read pages that are only executable. The block answers whether the access is allowed. When it is not, it gives the page-fault class to raise. When it is allowed, it says whether the entry's accessed or dirty bit must be set.

The checker is meant to sit in one pipeline stage. A request is sampled on a clock edge when `req_valid` is high, and the registered answer appears on the next cycle with `rsp_valid`. Between requests the response fields hold their last value. The handling of a clear accessed or dirty bit is fixed when the block is built. In the update scheme, the access is allowed and the update is requested. In the fault scheme, the access raises a page fault.

Top module: `pte_perm_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid`, `rsp_allow`, `rsp_reserved`, `rsp_set_a` and `rsp_set_d` are 0 and `rsp_fault` is 00.
- R2: `rsp_valid` equals `req_valid` of the previous cycle. After a cycle with `req_valid` low, every response field keeps its previous value.
- R3: Execute/write/read encodings 010 and 110 (write without read) are denied with `rsp_reserved`=1. Encoding 000 (a pointer, never a leaf) is denied with `rsp_reserved`=0. In both cases the fault class follows the access kind.
- R4: A fetch (`req_acc`=00) needs execute permission. If it is denied, `rsp_fault`=01.
- R5: A load or load-reserved (`req_acc`=01) needs read permission, or execute permission while `req_mxr`=1. If it is denied, `rsp_fault`=10.
- R6: A store or store-conditional (`req_acc`=10) and an AMO (`req_acc`=11) need write permission. If either is denied, `rsp_fault`=11. An AMO never yields 10.
- R7: In user mode (`req_priv`=0), an entry with the user bit clear denies every access.
- R8: In supervisor mode (`req_priv`=1), an entry with the user bit set denies every fetch, whatever `req_sum` is. It denies loads and stores unless `req_sum`=1.
- R9: With `AD_FAULT`=0, an otherwise permitted access is allowed. `rsp_set_a` is raised when the accessed bit is clear. `rsp_set_d` is raised when a store or AMO finds the dirty bit clear.
- R10: With `AD_FAULT`=1, an otherwise permitted access that finds the accessed bit clear, or a store or AMO that finds the dirty bit clear, is denied with its access-kind fault class. `rsp_set_a` and `rsp_set_d` stay 0.
- R11: `rsp_fault` is 00 exactly when `rsp_allow`=1. `rsp_set_a` and `rsp_set_d` are never raised on a denied access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_acc | input | 2 | Access kind: 00 fetch, 01 load/LR, 10 store/SC, 11 AMO |
| req_priv | input | 1 | 0 user, 1 supervisor |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| pte_r | input | 1 | Entry readable bit |
| pte_w | input | 1 | Entry writable bit |
| pte_x | input | 1 | Entry executable bit |
| pte_u | input | 1 | Entry user bit |
| pte_a | input | 1 | Entry accessed bit |
| pte_d | input | 1 | Entry dirty bit |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 2 | 00 none, 01 fetch, 10 load, 11 store page fault |
| rsp_reserved | output | 1 | Entry used a reserved encoding |
| rsp_set_a | output | 1 | Accessed bit must be set |
| rsp_set_d | output | 1 | Dirty bit must be set |

## Verification
The hardest cases to reach are those where several rules act on the same request. Examples are an AMO on an execute-only page with the execute-read modifier set, or a supervisor fetch from a user page with the user-access modifier set. A wrong precedence or a wrong fault class shows up only in such combinations. The stimulus therefore walks every combination of access kind, privilege, both modifiers and all 64 entry bit patterns. It does this on two instances, one for each accessed/dirty scheme. Idle cycles are inserted at intervals with the inputs scrambled, so that the hold behaviour is compared against the model as well.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  localparam int ACC_W   = 2;
  localparam int FAULT_W = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_AMO   = 2'b11
  } acc_e;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE  = 2'b00,
    FLT_FETCH = 2'b01,
    FLT_LOAD  = 2'b10,
    FLT_STORE = 2'b11
  } fault_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
    logic u;
    logic a;
    logic d;
  } pte_bits_t;

  typedef struct packed {
    logic   allow;
    fault_e fault;
    logic   reserved;
    logic   set_a;
    logic   set_d;
  } perm_rsp_t;

  // AMOs are reported as store faults, never as load faults
  function automatic fault_e fault_of(input acc_e acc);
    case (acc)
      ACC_FETCH: fault_of = FLT_FETCH;
      ACC_LOAD:  fault_of = FLT_LOAD;
      default:   fault_of = FLT_STORE;
    endcase
  endfunction

  function automatic logic is_write_kind(input acc_e acc);
    is_write_kind = (acc == ACC_STORE) || (acc == ACC_AMO);
  endfunction

endpackage

// File: rtl/pte_enc_decode.sv
module pte_enc_decode (
  input  logic r,
  input  logic w,
  input  logic x,
  output logic is_pointer,
  output logic is_reserved,
  output logic is_leaf
);
  always_comb begin
    is_pointer  = !r && !w && !x;
    is_reserved = !r && w;
    is_leaf     = !is_pointer && !is_reserved;
  end
endmodule

// File: rtl/pte_priv_gate.sv
module pte_priv_gate
  import pte_chk_pkg::*;
(
  input  acc_e      acc,
  input  logic      priv_sup,
  input  logic      sum,
  input  logic      mxr,
  input  pte_bits_t pte,
  output logic      priv_ok,
  output logic      perm_ok
);
  always_comb begin
    // privilege gate on the user bit
    if (!priv_sup) begin
      priv_ok = pte.u;
    end else if (pte.u) begin
      priv_ok = (acc != ACC_FETCH) && sum;
    end else begin
      priv_ok = 1'b1;
    end

    // permission bits per access kind
    case (acc)
      ACC_FETCH: perm_ok = pte.x;
      ACC_LOAD:  perm_ok = pte.r || (mxr && pte.x);
      default:   perm_ok = pte.w;
    endcase
  end
endmodule

// File: rtl/pte_ad_eval.sv
module pte_ad_eval
  import pte_chk_pkg::*;
#(
  parameter bit AD_FAULT = 1'b0
) (
  input  acc_e acc,
  input  logic base_ok,
  input  logic a,
  input  logic d,
  output logic allow,
  output logic set_a,
  output logic set_d
);
  logic need_a;
  logic need_d;

  always_comb begin
    need_a = !a;
    need_d = is_write_kind(acc) && !d;
  end

  generate
    if (AD_FAULT) begin : g_fault_scheme
      always_comb begin
        allow = base_ok && !need_a && !need_d;
        set_a = 1'b0;
        set_d = 1'b0;
      end
    end else begin : g_update_scheme
      always_comb begin
        allow = base_ok;
        set_a = base_ok && need_a;
        set_d = base_ok && need_d;
      end
    end
  endgenerate
endmodule

// File: rtl/pte_perm_checker.sv
module pte_perm_checker
  import pte_chk_pkg::*;
#(
  parameter bit AD_FAULT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [1:0]   req_acc,
  input  logic         req_priv,
  input  logic         req_sum,
  input  logic         req_mxr,
  input  logic         pte_r,
  input  logic         pte_w,
  input  logic         pte_x,
  input  logic         pte_u,
  input  logic         pte_a,
  input  logic         pte_d,
  output logic         rsp_valid,
  output logic         rsp_allow,
  output logic [1:0]   rsp_fault,
  output logic         rsp_reserved,
  output logic         rsp_set_a,
  output logic         rsp_set_d
);

  acc_e      acc;
  pte_bits_t pte;
  logic      is_pointer, is_reserved, is_leaf;
  logic      priv_ok, perm_ok, base_ok;
  logic      ad_allow, ad_set_a, ad_set_d;
  perm_rsp_t nxt, cur;
  logic      cur_valid;

  always_comb begin
    acc = acc_e'(req_acc);
    pte = '{r: pte_r, w: pte_w, x: pte_x, u: pte_u, a: pte_a, d: pte_d};
  end

  pte_enc_decode u_dec (
    .r           (pte_r),
    .w           (pte_w),
    .x           (pte_x),
    .is_pointer  (is_pointer),
    .is_reserved (is_reserved),
    .is_leaf     (is_leaf)
  );

  pte_priv_gate u_gate (
    .acc      (acc),
    .priv_sup (req_priv),
    .sum      (req_sum),
    .mxr      (req_mxr),
    .pte      (pte),
    .priv_ok  (priv_ok),
    .perm_ok  (perm_ok)
  );

  assign base_ok = is_leaf && priv_ok && perm_ok;

  pte_ad_eval #(.AD_FAULT(AD_FAULT)) u_ad (
    .acc     (acc),
    .base_ok (base_ok),
    .a       (pte_a),
    .d       (pte_d),
    .allow   (ad_allow),
    .set_a   (ad_set_a),
    .set_d   (ad_set_d)
  );

  always_comb begin
    nxt.allow    = ad_allow;
    nxt.fault    = ad_allow ? FLT_NONE : fault_of(acc);
    nxt.reserved = is_reserved;
    nxt.set_a    = ad_set_a;
    nxt.set_d    = ad_set_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur       <= '{allow: 1'b0, fault: FLT_NONE, reserved: 1'b0,
                     set_a: 1'b0, set_d: 1'b0};
    end else begin
      cur_valid <= req_valid;
      if (req_valid) cur <= nxt;
    end
  end

  assign rsp_valid    = cur_valid;
  assign rsp_allow    = cur.allow;
  assign rsp_fault    = cur.fault;
  assign rsp_reserved = cur.reserved;
  assign rsp_set_a    = cur.set_a;
  assign rsp_set_d    = cur.set_d;

  // R2: response valid tracks request one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_allow) && $stable(rsp_fault) && $stable(rsp_set_a)));
  // R3: reserved encodings never allowed
  a_r3_reserved_denied: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pte_r && pte_w) |=> (rsp_reserved && !rsp_allow));
  // R6: AMO never reports a load fault
  a_r6_amo_no_load_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_acc == 2'b11) |=> (rsp_fault != 2'b10));
  // R8: supervisor fetch from user page denied
  a_r8_sup_user_fetch: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv && pte_u && req_acc == 2'b00) |=> !rsp_allow);
  // R7: user mode needs user bit
  a_r7_user_needs_u: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_priv && !pte_u) |=> !rsp_allow);
  // R11: update requests only on allowed accesses
  a_r11_set_implies_allow: assert property (@(posedge clk) disable iff (rst)
    (rsp_set_a || rsp_set_d) |-> rsp_allow);
  a_r11_allow_no_fault: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> (rsp_fault == 2'b00));

endmodule

// File: tb/pte_perm_checker_test.sv
module pte_perm_checker_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0;
  logic [1:0] req_acc = 2'b00;
  logic       req_priv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic       pte_r = 1'b0, pte_w = 1'b0, pte_x = 1'b0;
  logic       pte_u = 1'b0, pte_a = 1'b0, pte_d = 1'b0;

  logic       v0, al0, rs0, sa0, sd0;
  logic [1:0] f0;
  logic       v1, al1, rs1, sa1, sd1;
  logic [1:0] f1;

  pte_perm_checker #(.AD_FAULT(1'b0)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_acc(req_acc),
    .req_priv(req_priv), .req_sum(req_sum), .req_mxr(req_mxr),
    .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
    .pte_a(pte_a), .pte_d(pte_d),
    .rsp_valid(v0), .rsp_allow(al0), .rsp_fault(f0),
    .rsp_reserved(rs0), .rsp_set_a(sa0), .rsp_set_d(sd0));

  pte_perm_checker #(.AD_FAULT(1'b1)) uut_flt (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_acc(req_acc),
    .req_priv(req_priv), .req_sum(req_sum), .req_mxr(req_mxr),
    .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
    .pte_a(pte_a), .pte_d(pte_d),
    .rsp_valid(v1), .rsp_allow(al1), .rsp_fault(f1),
    .rsp_reserved(rs1), .rsp_set_a(sa1), .rsp_set_d(sd1));

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // expected response, packed as {allow, fault[1:0], reserved, set_a, set_d}
  logic [5:0] exp0 = '0, exp1 = '0;
  string      tag0 = "R1", tag1 = "R1";

  function automatic void model(input logic [1:0] acc, input logic priv, sum, mxr,
                                input logic r, w, x, u, a, d, input bit adflt,
                                output logic [5:0] res, output string tag);
    logic [1:0] fc;
    logic ok, resv, sa, sd;
    fc = (acc == 2'd0) ? 2'd1 : (acc == 2'd1) ? 2'd2 : 2'd3;
    ok = 1'b0; resv = 1'b0; sa = 1'b0; sd = 1'b0;
    if (!r && w) begin
      resv = 1'b1; tag = "R3";
    end else if (!r && !w && !x) begin
      tag = "R3";
    end else if (!priv && !u) begin
      tag = "R7";
    end else if (priv && u && acc == 2'd0) begin
      tag = "R8";
    end else if (priv && u && !sum) begin
      tag = "R8";
    end else begin
      if (acc == 2'd0)      begin ok = x;               tag = "R4"; end
      else if (acc == 2'd1) begin ok = r || (mxr && x); tag = "R5"; end
      else                  begin ok = w;               tag = "R6"; end
      if (ok) begin
        sa = !a;
        sd = (acc >= 2'd2) && !d;
        if (adflt && (sa || sd)) begin
          ok = 1'b0; sa = 1'b0; sd = 1'b0; tag = "R10";
        end else if (sa || sd) begin
          tag = "R9";
        end else begin
          tag = "R11";
        end
      end
    end
    res = {ok, ok ? 2'd0 : fc, resv, sa, sd};
  endfunction

  task automatic compare(input string which, input string tag,
                         input logic v, input logic exp_v,
                         input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (v !== exp_v || act !== exp) begin
      fails++;
      $display("FAIL %s %s: got valid=%b rsp=%b expected valid=%b rsp=%b",
               tag, which, v, act, exp_v, exp);
    end
  endtask

  task automatic check_both(input logic exp_v, input string t0, input string t1);
    compare("uut", t0, v0, exp_v, {al0, f0, rs0, sa0, sd0}, exp0);
    compare("uut_flt", t1, v1, exp_v, {al1, f1, rs1, sa1, sd1}, exp1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no completion expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state during and just after reset
    repeat (3) @(negedge clk);
    check_both(1'b0, "R1", "R1");
    rst = 1'b0;
    @(negedge clk);
    check_both(1'b0, "R1", "R1");

    for (int i = 0; i < 2048; i++) begin
      logic [10:0] s;
      s = i[10:0];
      @(negedge clk);
      req_valid = 1'b1;
      {req_acc, req_priv, req_sum, req_mxr} = s[10:6];
      {pte_r, pte_w, pte_x, pte_u, pte_a, pte_d} = s[5:0];
      model(req_acc, req_priv, req_sum, req_mxr, pte_r, pte_w, pte_x,
            pte_u, pte_a, pte_d, 1'b0, exp0, tag0);
      model(req_acc, req_priv, req_sum, req_mxr, pte_r, pte_w, pte_x,
            pte_u, pte_a, pte_d, 1'b1, exp1, tag1);
      @(negedge clk);
      check_both(1'b1, tag0, tag1);
      if ((i % 7) == 3) begin
        // R2: idle with scrambled inputs, response holds
        req_valid = 1'b0;
        {req_acc, req_priv, req_sum, req_mxr} = ~s[10:6];
        {pte_r, pte_w, pte_x, pte_u, pte_a, pte_d} = ~s[5:0];
        @(negedge clk);
        check_both(1'b0, "R2", "R2");
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check_both(1'b0, "R2", "R2");
    finish_run();
  end

endmodule